// File: doc/BRIEF.md
# Auto-Reload Up-Counter with Update Control

This block is the counting core of a general-purpose time base. A 16-bit counter climbs by one on each prescaler tick while it is running. When it stands at the reload limit, the next tick returns it to zero and marks an overflow. An overflow, or a software request written to the event register, produces an update event. On an update event the block loads the buffered reload value and sets a sticky update flag. The event is also presented to the prescaler, so that the prescaler can take a new ratio at that point. The prescaler itself lies outside the block: it delivers `tick_i`, and it restarts its own count on `psc_clr_o`.

Software drives the block through a single register write port and a combinational read port. Control bits decide the following: whether the reload value is buffered, whether updates are suppressed, whether a software request sets the flag, whether the counter stops after one period, and whether the flag is copied into the top bit of the counter readback. A trigger selector sends the request pulse, the run bit or the update event to `trig_o` for downstream converters or timers. An interrupt request and a DMA pulse are derived from the flag and from the update event.

Top module: `reload_timer`

Register selects (`wr_sel_i`/`rd_sel_i`): 0 control, 1 trigger select, 2 request enables, 3 status, 4 event, 5 counter, 6 reload. Every register write takes effect at the clock edge that samples it.

## Requirements
- R1: After reset the counter reads 0, the reload register reads 0xFFFF, the status flag reads 0, and `upd_o`, `psc_clr_o`, `trig_o`, `irq_o` and `dma_o` are all low.
- R2: While control bit 0 (run) is 1, each cycle with `tick_i` high adds one to the counter. With `tick_i` low or run at 0, the counter holds. A tick taken at the reload limit returns the counter to 0, and `upd_o` is high for the one cycle after that edge.
- R3: While the effective reload limit is 0, ticks leave the counter unchanged and raise no overflow.
- R4: With control bit 4 (buffered reload) at 0, a write to the reload register becomes the limit at once. With it at 1, a write goes only to the buffer, which the reload register reads back, and the limit takes the buffer's value at the next update event.
- R5: Writing 1 to event bit 0 clears the counter and pulses `psc_clr_o` for one cycle. Unless updates are disabled, it also produces an update event.
- R6: With control bit 1 (update disable) at 1, an overflow still returns the counter to 0, but there is no `upd_o` pulse, the flag is not set and the limit is not reloaded.
- R7: With control bit 2 (overflow-only flag) at 1, an update from the event register leaves the flag clear, while an overflow update still sets it.
- R8: The status flag is set by every update event that is allowed to set it, and it stays set. Writing status bit 0 as 0 clears it. Writing it as 1 has no effect.
- R9: With control bit 3 (one-shot) at 1, an update event clears the run bit, and counting stops.
- R10: With control bit 5 (flag copy) at 1, counter readback bit 31 equals the status flag in the same cycle. With it at 0, bit 31 reads 0.
- R11: Trigger select 0 routes the event-register request pulse to `trig_o`, select 1 routes the run bit, and select 2 routes the update pulse.
- R12: `irq_o` is the status flag gated by enable bit 0. `dma_o` is the update pulse gated by enable bit 1.
- R13: A counter write takes effect at the next edge and wins over a tick in the same cycle.
- R14: An overflow tick and an event request in the same cycle yield a single one-cycle update pulse and leave the counter at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaler tick, one cycle per count |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select for the write |
| wr_data_i | input | 16 | Write data |
| rd_sel_i | input | 3 | Register select for the readback |
| rd_data_o | output | 32 | Readback of the selected register |
| upd_o | output | 1 | Update event pulse, which also loads the prescaler ratio |
| psc_clr_o | output | 1 | Restart pulse for the prescaler count |
| trig_o | output | 1 | Selected trigger output |
| irq_o | output | 1 | Update interrupt request |
| dma_o | output | 1 | Update DMA request pulse |

## Verification
The hardest case to reach is a software request that lands in the very cycle the counter overflows. The stimulus raises the counter to the limit and then drives a tick and the event write together on one edge, and expects a single update pulse. The buffered reload path is almost as elusive, because it must show that a new limit stays dormant for a whole period. The bench first turns buffering on, so that the limit is captured. It then writes a smaller value and watches the counter pass that value and wrap at the old limit before it adopts the new one. Update suppression is shown in the same way: with updates off, the counter goes on wrapping at the stale limit.

// File: rtl/timer_pkg.sv
package timer_pkg;

    typedef enum logic [2:0] {
        SEL_CTRL   = 3'd0,
        SEL_TRIG   = 3'd1,
        SEL_REQEN  = 3'd2,
        SEL_STAT   = 3'd3,
        SEL_EVENT  = 3'd4,
        SEL_COUNT  = 3'd5,
        SEL_RELOAD = 3'd6
    } reg_sel_e;

    typedef enum logic [2:0] {
        TRG_REQ = 3'd0,
        TRG_RUN = 3'd1,
        TRG_UPD = 3'd2
    } trig_sel_e;

    typedef struct packed {
        logic flag_copy;
        logic buffered;
        logic one_shot;
        logic ovf_only;
        logic upd_off;
        logic run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/timer_count.sv
module timer_count #(
    parameter int CW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          run_i,
    input  logic          upd_off_i,
    input  logic          buffered_i,
    input  logic          req_i,
    input  logic          cnt_wr_i,
    input  logic          rl_wr_i,
    input  logic [CW-1:0] wr_data_i,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] buf_o,
    output logic          ovf_o,
    output logic          uev_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] rl_buf;
        logic [CW-1:0] rl_shadow;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic [CW-1:0] limit;
    logic          adv, ovf, uev;

    always_comb begin
        limit = buffered_i ? s_q.rl_shadow : s_q.rl_buf;
        adv   = run_i && tick_i && (limit != '0);
        ovf   = adv && (s_q.cnt == limit);
        uev   = !upd_off_i && (ovf || req_i);

        s_d = s_q;
        if (cnt_wr_i)          s_d.cnt = wr_data_i;
        else if (req_i || ovf) s_d.cnt = '0;
        else if (adv)          s_d.cnt = s_q.cnt + 1'b1;

        if (rl_wr_i) s_d.rl_buf = wr_data_i;
        if (!buffered_i || uev) s_d.rl_shadow = s_q.rl_buf;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.cnt       <= '0;
            s_q.rl_buf    <= '1;
            s_q.rl_shadow <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o = s_q.cnt;
    assign buf_o = s_q.rl_buf;
    assign ovf_o = ovf;
    assign uev_o = uev;

    assert_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf && !cnt_wr_i) |=> (s_q.cnt == '0));

    assert_zero_limit_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (limit == '0 && !cnt_wr_i && !req_i) |=> $stable(s_q.cnt));

    assert_buffer_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (buffered_i && !uev) |=> $stable(s_q.rl_shadow));

    assert_req_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !cnt_wr_i) |=> (s_q.cnt == '0));

endmodule

// File: rtl/timer_regs.sv
module timer_regs
    import timer_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_sel_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    input  logic              uev_i,
    input  logic              ovf_i,
    output ctrl_t             ctrl_o,
    output logic [2:0]        trig_sel_o,
    output logic              irq_en_o,
    output logic              dma_en_o,
    output logic              flag_o,
    output logic              req_o,
    output logic              cnt_wr_o,
    output logic              rl_wr_o
);

    typedef struct packed {
        ctrl_t      ctrl;
        logic [2:0] trig_sel;
        logic       irq_en;
        logic       dma_en;
        logic       flag;
    } reg_state_t;

    reg_state_t r_d, r_q;
    reg_sel_e   sel;
    logic       ctrl_wr, stat_clr, flag_set;

    always_comb begin
        sel      = reg_sel_e'(wr_sel_i);
        ctrl_wr  = wr_en_i && (sel == SEL_CTRL);
        stat_clr = wr_en_i && (sel == SEL_STAT) && !wr_data_i[0];
        req_o    = wr_en_i && (sel == SEL_EVENT) && wr_data_i[0];
        cnt_wr_o = wr_en_i && (sel == SEL_COUNT);
        rl_wr_o  = wr_en_i && (sel == SEL_RELOAD);
        flag_set = uev_i && (!r_q.ctrl.ovf_only || ovf_i);

        r_d = r_q;
        if (ctrl_wr) r_d.ctrl = ctrl_t'(wr_data_i);
        if (uev_i && r_q.ctrl.one_shot) r_d.ctrl.run = 1'b0;
        if (wr_en_i && sel == SEL_TRIG) r_d.trig_sel = wr_data_i[2:0];
        if (wr_en_i && sel == SEL_REQEN) begin
            r_d.irq_en = wr_data_i[0];
            r_d.dma_en = wr_data_i[1];
        end
        if (flag_set)      r_d.flag = 1'b1;
        else if (stat_clr) r_d.flag = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign ctrl_o     = r_q.ctrl;
    assign trig_sel_o = r_q.trig_sel;
    assign irq_en_o   = r_q.irq_en;
    assign dma_en_o   = r_q.dma_en;
    assign flag_o     = r_q.flag;

    assert_flag_no_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && !ovf_i && r_q.ctrl.ovf_only && !r_q.flag) |=> !r_q.flag);

    assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.flag && !stat_clr) |=> r_q.flag);

    assert_one_shot_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (uev_i && r_q.ctrl.one_shot && !ctrl_wr) |=> !r_q.ctrl.run);

endmodule

// File: rtl/timer_out.sv
module timer_out
    import timer_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       uev_i,
    input  logic       req_i,
    input  logic       run_i,
    input  logic       flag_i,
    input  logic       irq_en_i,
    input  logic       dma_en_i,
    input  logic [2:0] trig_sel_i,
    output logic       upd_o,
    output logic       psc_clr_o,
    output logic       trig_o,
    output logic       irq_o,
    output logic       dma_o
);

    typedef struct packed {
        logic upd;
        logic req;
        logic dma;
    } pulse_t;

    pulse_t p_d, p_q;

    always_comb begin
        p_d.upd = uev_i;
        p_d.req = req_i;
        p_d.dma = uev_i && dma_en_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) p_q <= '0;
        else         p_q <= p_d;
    end

    always_comb begin
        case (trig_sel_e'(trig_sel_i))
            TRG_REQ: trig_o = p_q.req;
            TRG_RUN: trig_o = run_i;
            TRG_UPD: trig_o = p_q.upd;
            default: trig_o = 1'b0;
        endcase
    end

    assign upd_o     = p_q.upd;
    assign psc_clr_o = p_q.req;
    assign dma_o     = p_q.dma;
    assign irq_o     = flag_i && irq_en_i;

    assert_dma_needs_update_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dma_o |-> upd_o);

    assert_update_one_cycle_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (uev_i && !req_i) |=> upd_o);

endmodule

// File: rtl/reload_timer.sv
module reload_timer
    import timer_pkg::*;
#(
    parameter int CW = 16,
    parameter int RW = 2 * CW
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          wr_en_i,
    input  logic [2:0]    wr_sel_i,
    input  logic [CW-1:0] wr_data_i,
    input  logic [2:0]    rd_sel_i,
    output logic [RW-1:0] rd_data_o,
    output logic          upd_o,
    output logic          psc_clr_o,
    output logic          trig_o,
    output logic          irq_o,
    output logic          dma_o
);

    ctrl_t         ctrl;
    logic [2:0]    trig_sel;
    logic          irq_en, dma_en, flag, req, cnt_wr, rl_wr;
    logic          ovf, uev;
    logic [CW-1:0] cnt, rl_buf;

    timer_regs u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_sel_i   (wr_sel_i),
        .wr_data_i  (wr_data_i[CTRL_W-1:0]),
        .uev_i      (uev),
        .ovf_i      (ovf),
        .ctrl_o     (ctrl),
        .trig_sel_o (trig_sel),
        .irq_en_o   (irq_en),
        .dma_en_o   (dma_en),
        .flag_o     (flag),
        .req_o      (req),
        .cnt_wr_o   (cnt_wr),
        .rl_wr_o    (rl_wr)
    );

    timer_count #(.CW(CW)) u_count (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick_i),
        .run_i      (ctrl.run),
        .upd_off_i  (ctrl.upd_off),
        .buffered_i (ctrl.buffered),
        .req_i      (req),
        .cnt_wr_i   (cnt_wr),
        .rl_wr_i    (rl_wr),
        .wr_data_i  (wr_data_i),
        .cnt_o      (cnt),
        .buf_o      (rl_buf),
        .ovf_o      (ovf),
        .uev_o      (uev)
    );

    timer_out u_out (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .uev_i      (uev),
        .req_i      (req),
        .run_i      (ctrl.run),
        .flag_i     (flag),
        .irq_en_i   (irq_en),
        .dma_en_i   (dma_en),
        .trig_sel_i (trig_sel),
        .upd_o      (upd_o),
        .psc_clr_o  (psc_clr_o),
        .trig_o     (trig_o),
        .irq_o      (irq_o),
        .dma_o      (dma_o)
    );

    always_comb begin
        rd_data_o = '0;
        case (reg_sel_e'(rd_sel_i))
            SEL_CTRL:   rd_data_o[CTRL_W-1:0] = ctrl;
            SEL_TRIG:   rd_data_o[2:0]        = trig_sel;
            SEL_REQEN:  rd_data_o[1:0]        = {dma_en, irq_en};
            SEL_STAT:   rd_data_o[0]          = flag;
            SEL_COUNT: begin
                rd_data_o[CW-1:0] = cnt;
                rd_data_o[RW-1]   = ctrl.flag_copy && flag;
            end
            SEL_RELOAD: rd_data_o[CW-1:0]     = rl_buf;
            default:    rd_data_o             = '0;
        endcase
    end

    assert_copy_bit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_sel_i == SEL_COUNT && !ctrl.flag_copy) |-> !rd_data_o[RW-1]);

    assert_upd_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl.upd_off |=> !upd_o);

endmodule

// File: tb/reload_timer_bench.sv
module reload_timer_bench;
    import timer_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        upd, psc_clr, trig, irq, dma;

    always #(CLK_PERIOD/2) clk = ~clk;

    reload_timer u_reload_timer (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
        .wr_sel_i(wr_sel), .wr_data_i(wr_data), .rd_sel_i(rd_sel),
        .rd_data_o(rd_data), .upd_o(upd), .psc_clr_o(psc_clr),
        .trig_o(trig), .irq_o(irq), .dma_o(dma)
    );

    // output vector bits: 4 upd, 3 psc_clr, 2 trig, 1 irq, 0 dma
    localparam logic [4:0] O_UPD = 5'b10000, O_CLR = 5'b01000,
                           O_TRG = 5'b00100, O_IRQ = 5'b00010, O_DMA = 5'b00001;

    typedef struct {
        int          cyc;
        bit          is_out;
        logic [31:0] mask;
        logic [31:0] val;
        string       tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops every expectation due in this cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            item_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = it.is_out ? {27'd0, upd, psc_clr, trig, irq, dma} : rd_data;
            checks++;
            if (it.cyc != cyc || (act & it.mask) !== (it.val & it.mask)) begin
                fails++;
                $display("FAIL %s: actual %h expected %h (mask %h)",
                         it.tag, act & it.mask, it.val & it.mask, it.mask);
            end
        end
    end

    task automatic go();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        go();
        wr_en = 1'b0;
    endtask

    task automatic tk(input int n);
        tick = 1'b1;
        repeat (n) go();
        tick = 1'b0;
    endtask

    task automatic exp_rd(input logic [2:0] s, input logic [31:0] v, input string tag);
        rd_sel = s;
        q.push_back('{cyc, 1'b0, 32'hFFFF_FFFF, v, tag});
        go();
    endtask

    task automatic exp_out(input logic [4:0] m, input logic [4:0] v, input string tag);
        q.push_back('{cyc, 1'b1, {27'd0, m}, {27'd0, v}, tag});
        go();
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) go();
        rst_n = 1'b1;
        go();
        // R1 reset state
        exp_out(5'h1F, 5'h00, "R1 outputs low");
        exp_rd(SEL_COUNT,  32'h0,    "R1 counter");
        exp_rd(SEL_RELOAD, 32'hFFFF, "R1 reload");
        exp_rd(SEL_STAT,   32'h0,    "R1 flag");

        // R2 counting and wrap
        wr(SEL_RELOAD, 16'd5);
        wr(SEL_CTRL, 16'h01);
        tk(3);
        exp_rd(SEL_COUNT, 32'd3, "R2 counts ticks");
        go(); go();
        exp_rd(SEL_COUNT, 32'd3, "R2 holds without tick");
        tk(2);
        exp_out(O_UPD, 5'h00, "R2 no update at limit");
        tk(1);
        exp_out(O_UPD, O_UPD, "R2 update after wrap");
        exp_out(O_UPD, 5'h00, "R2 update one cycle");
        exp_rd(SEL_COUNT, 32'd0, "R2 wrapped to zero");

        // R8 sticky flag
        exp_rd(SEL_STAT, 32'd1, "R8 flag set by overflow");
        wr(SEL_STAT, 16'd1);
        exp_rd(SEL_STAT, 32'd1, "R8 writing one keeps flag");
        wr(SEL_STAT, 16'd0);
        exp_rd(SEL_STAT, 32'd0, "R8 writing zero clears flag");

        // R12 interrupt and dma
        wr(SEL_REQEN, 16'd3);
        tk(6);
        exp_out(O_UPD | O_IRQ | O_DMA, O_UPD | O_IRQ | O_DMA, "R12 irq and dma on update");
        exp_out(O_UPD | O_IRQ | O_DMA, O_IRQ, "R12 dma pulse ends, irq held");
        wr(SEL_STAT, 16'd0);
        exp_out(O_IRQ, 5'h00, "R12 irq drops with flag");
        wr(SEL_REQEN, 16'd0);

        // R11 trigger select, R5 request
        wr(SEL_TRIG, 16'd1);
        exp_out(O_TRG, O_TRG, "R11 trigger follows run");
        wr(SEL_CTRL, 16'h00);
        exp_out(O_TRG, 5'h00, "R11 trigger follows run low");
        wr(SEL_TRIG, 16'd2);
        wr(SEL_COUNT, 16'd3);
        wr(SEL_EVENT, 16'd1);
        exp_out(O_UPD | O_CLR | O_TRG, O_UPD | O_CLR | O_TRG, "R5 R11 request update on trigger");
        exp_rd(SEL_COUNT, 32'd0, "R5 request clears counter");
        wr(SEL_TRIG, 16'd0);
        wr(SEL_EVENT, 16'd1);
        exp_out(O_TRG | O_CLR, O_TRG | O_CLR, "R11 trigger carries request pulse");

        // R13 counter write beats tick
        wr(SEL_CTRL, 16'h01);
        tick = 1'b1;
        wr(SEL_COUNT, 16'd2);
        tick = 1'b0;
        exp_rd(SEL_COUNT, 32'd2, "R13 write overrides tick");

        // R3 zero limit
        wr(SEL_RELOAD, 16'd0);
        tk(4);
        exp_rd(SEL_COUNT, 32'd2, "R3 zero limit holds counter");
        wr(SEL_COUNT, 16'd0);
        tk(3);
        exp_out(O_UPD, 5'h00, "R3 no overflow at zero limit");
        exp_rd(SEL_COUNT, 32'd0, "R3 counter still zero");

        // R4 buffered reload
        wr(SEL_RELOAD, 16'd4);
        wr(SEL_CTRL, 16'h11);
        wr(SEL_RELOAD, 16'd2);
        exp_rd(SEL_RELOAD, 32'd2, "R4 buffer reads back");
        tk(3);
        tk(1);
        exp_out(O_UPD, 5'h00, "R4 old limit still active");
        exp_rd(SEL_COUNT, 32'd4, "R4 passed new value");
        tk(1);
        exp_out(O_UPD, O_UPD, "R4 wrap at old limit");
        tk(2);
        tk(1);
        exp_out(O_UPD, O_UPD, "R4 new limit after update");

        // R6 update disable
        wr(SEL_CTRL, 16'h13);
        wr(SEL_STAT, 16'd0);
        wr(SEL_RELOAD, 16'd3);
        tk(2);
        tk(1);
        exp_out(O_UPD, 5'h00, "R6 no update on overflow");
        exp_rd(SEL_STAT, 32'd0, "R6 flag not set");
        tk(3);
        exp_rd(SEL_COUNT, 32'd0, "R6 limit not reloaded");
        tk(1);
        wr(SEL_EVENT, 16'd1);
        exp_out(O_UPD | O_CLR, O_CLR, "R5 request with updates off");
        exp_rd(SEL_COUNT, 32'd0, "R5 counter cleared with updates off");

        // R7 overflow-only flag
        wr(SEL_CTRL, 16'h15);
        wr(SEL_EVENT, 16'd1);
        exp_out(O_UPD, O_UPD, "R7 request still updates");
        exp_rd(SEL_STAT, 32'd0, "R7 request leaves flag clear");
        tk(3);
        tk(1);
        exp_out(O_UPD, O_UPD, "R7 overflow update");
        exp_rd(SEL_STAT, 32'd1, "R7 overflow sets flag");

        // R14 overflow and request together
        tk(3);
        tick = 1'b1;
        wr(SEL_EVENT, 16'd1);
        tick = 1'b0;
        exp_out(O_UPD, O_UPD, "R14 single update");
        exp_out(O_UPD, 5'h00, "R14 no second update");
        exp_rd(SEL_COUNT, 32'd0, "R14 counter zero");

        // R9 one-shot
        wr(SEL_CTRL, 16'h09);
        tk(4);
        exp_out(O_UPD, O_UPD, "R9 one-shot update");
        exp_rd(SEL_CTRL, 32'h08, "R9 run cleared");
        tk(2);
        exp_rd(SEL_COUNT, 32'd0, "R9 counter stopped");

        // R10 flag copy
        wr(SEL_CTRL, 16'h20);
        exp_rd(SEL_COUNT, 32'h8000_0000, "R10 flag copied to bit 31");
        wr(SEL_CTRL, 16'h00);
        exp_rd(SEL_COUNT, 32'h0, "R10 bit 31 zero without copy");
        wr(SEL_STAT, 16'd0);
        wr(SEL_CTRL, 16'h20);
        exp_rd(SEL_COUNT, 32'h0, "R10 copy of clear flag");

        go();
        if (q.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
        end
        report();
    end

endmodule